// File: doc/BRIEF.md
# Sub-prefix node update unit

This block maintains routes whose length inside the last node of a multibit trie is shorter than the node stride K. It updates one node, chosen by its segment number. Each such route is kept in a per-word side field (RS) at an offset that encodes both its bits and its length. The route is also spread into every full-width word that it covers. Each word keeps a length bitmask (VSP) and a full-prefix flag (F). On insert, these decide whether the word's active route R is overwritten. On delete, they decide whether R stays, is restored from a shorter route, or is invalidated. The node's child count is kept consistent as words become valid or empty.

A request gives an operation, a segment, a length L from 1 to K-1, the sub-prefix bits and a route. The unit then runs a fixed sequence of reads and writes on a single-port memory with one-cycle read latency and pulses `done` when the sequence ends. Walking the upper trie levels and allocating nodes are handled elsewhere.

Top module: `subpfx_node_upd`

## Requirements
- R1: The RS offset of a length-L sub-prefix p is p followed by a single 1 and then K-1-L zeros. For K=4, the 3-bit value abc goes to abc1, the 2-bit value ab to ab10, and the 1-bit value a to a100. Insert writes the route into RS at that offset. Delete writes 0 there.
- R2: An operation visits the 2^(K-L) offsets that begin with p, in ascending order. In each one it sets VSP bit L-1 (bit 0 is length 1) on insert and clears that bit on delete. Bits of `sp_val` at position L and above are ignored.
- R3: Insert into a word with V=0 writes R with the route and sets V. The child count rises by one only if that word's S flag is 1.
- R4: Insert into a word with V=1 replaces R only if F=0 and no VSP bit above L-1 is set. F is never changed.
- R5: Delete leaves R and V unchanged in a word with F=1, with V=0, or with a VSP bit above L-1 still set.
- R6: Delete into a word with V=1 and F=0, where only shorter VSP bits remain, reloads R from RS. The RS is read at the encoded offset (per R1) of the longest remaining length, using that length's leading bits of the word's own offset.
- R7: Delete into a word with V=1 and F=0 and no VSP bit remaining clears V. The child count falls by one only if S=1. R is left as it was.
- R8: The child count sits in the offset-0 word of the node and is updated once, by the net change, after the last word. `done` is then high for exactly one cycle. A `start` while an operation runs is ignored.
- R9: The memory address is {segment, offset}. Every word change is a read followed by a write to the same word. Read and write are never issued in the same cycle, and read data arrives one cycle after the read. The word layout from the LSB up is: V bit 0, S bit 1, F bit 2, VSP in K-1 bits from bit 3, then R (R_W bits), then RS (R_W bits), then the count (K+1 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 1 | 0 insert, 1 delete |
| seg | input | SEG_W | Node segment |
| sp_len | input | LW | Sub-prefix length, 1 to K-1 |
| sp_val | input | K-1 | Sub-prefix bits, right aligned |
| route | input | R_W | Route for insert |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | SEG_W+K | Memory word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid one cycle after mem_re |

## Verification
The bench builds the unit with K=4, SEG_W=3 and R_W=8, so every sub-prefix length from 1 to 3 can be used. With these values, one node holds a full-prefix word, a word with a child, and routes of all three lengths overlapping in the same words. That makes reachable both the restore from a two-step shorter route and the keep-on-longer rule in insert and in delete. A second segment shows that the address is {segment, offset} and that a start issued mid-run leaves the memory untouched.

// File: rtl/subpfx_pkg.sv
package subpfx_pkg;

  typedef enum logic {
    OP_INS = 1'b0,
    OP_DEL = 1'b1
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RS_RD,
    ST_RS_WR,
    ST_EX_RD,
    ST_EX_WR,
    ST_RT_RD,
    ST_RT_WR,
    ST_CC_RD,
    ST_CC_WR,
    ST_FIN
  } step_e;

endpackage

// File: rtl/subpfx_addr_gen.sv
module subpfx_addr_gen #(
  parameter int K  = 4,
  parameter int LW = $clog2(K)
) (
  input  logic [LW-1:0] len,
  input  logic [K-2:0]  val,
  input  logic [K-1:0]  cnt,
  input  logic [LW-1:0] rlen,
  output logic [K-1:0]  rs_off,
  output logic [K-1:0]  exp_off,
  output logic [K-1:0]  rst_off,
  output logic          last
);
  localparam logic [K-1:0] K_ONE = 1;

  // leading l bits kept, rest cleared
  function automatic logic [K-1:0] keep_top(input int l);
    return ~((K_ONE << (K - l)) - K_ONE);
  endfunction

  // single 1 right after the l leading bits
  function automatic logic [K-1:0] marker(input int l);
    return K_ONE << (K - 1 - l);
  endfunction

  logic [K-1:0] base;

  always_comb begin
    base    = {1'b0, val} << (K - int'(len));
    rs_off  = base | marker(int'(len));
    exp_off = base | cnt;
    rst_off = (exp_off & keep_top(int'(rlen))) | marker(int'(rlen));
    last    = (cnt == ((K_ONE << (K - int'(len))) - K_ONE));
  end

endmodule

// File: rtl/subpfx_word_rule.sv
module subpfx_word_rule #(
  parameter int K  = 4,
  parameter int LW = $clog2(K)
) (
  input  logic          del,
  input  logic [LW-1:0] len,
  input  logic          cur_v,
  input  logic          cur_s,
  input  logic          cur_f,
  input  logic [K-2:0]  cur_vsp,
  output logic          nxt_v,
  output logic [K-2:0]  nxt_vsp,
  output logic          take_route,
  output logic          need_rst,
  output logic [LW-1:0] rst_len,
  output logic          cc_up,
  output logic          cc_dn
);
  localparam int VL = K - 1;
  localparam logic [VL-1:0] V_ONE = 1;

  function automatic logic [VL-1:0] len_bit(input int l);
    return V_ONE << (l - 1);
  endfunction

  function automatic logic [VL-1:0] longer_bits(input int l);
    return ~((V_ONE << l) - V_ONE);
  endfunction

  logic [VL-1:0] lb, longer, shorter;

  always_comb begin
    lb         = len_bit(int'(len));
    longer     = longer_bits(int'(len));
    shorter    = lb - V_ONE;
    nxt_vsp    = del ? (cur_vsp & ~lb) : (cur_vsp | lb);
    nxt_v      = cur_v;
    take_route = 1'b0;
    need_rst   = 1'b0;
    rst_len    = '0;
    cc_up      = 1'b0;
    cc_dn      = 1'b0;
    if (!del) begin
      if (!cur_v) begin
        take_route = 1'b1;
        nxt_v      = 1'b1;
        cc_up      = cur_s;
      end else begin
        take_route = !cur_f && ((nxt_vsp & longer) == '0);
      end
    end else if (cur_v && !cur_f && ((nxt_vsp & longer) == '0)) begin
      if ((nxt_vsp & shorter) != '0) begin
        need_rst = 1'b1;
        for (int i = 0; i < VL; i++) begin
          if (nxt_vsp[i] && (i < int'(len) - 1)) rst_len = LW'(i + 1);
        end
      end else begin
        nxt_v = 1'b0;
        cc_dn = cur_s;
      end
    end
  end

endmodule

// File: rtl/subpfx_node_upd.sv
module subpfx_node_upd
  import subpfx_pkg::*;
#(
  parameter int K      = 4,
  parameter int SEG_W  = 4,
  parameter int R_W    = 8,
  parameter int LW     = $clog2(K),
  parameter int WORD_W = 3 + (K - 1) + 2 * R_W + (K + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 op,
  input  logic [SEG_W-1:0]     seg,
  input  logic [LW-1:0]        sp_len,
  input  logic [K-2:0]         sp_val,
  input  logic [R_W-1:0]       route,
  output logic                 done,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [SEG_W+K-1:0]   mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata
);
  localparam int CC_W  = K + 1;
  localparam int P_V   = 0;
  localparam int P_S   = 1;
  localparam int P_F   = 2;
  localparam int P_VSP = 3;
  localparam int P_R   = P_VSP + K - 1;
  localparam int P_RS  = P_R + R_W;
  localparam int P_CC  = P_RS + R_W;
  localparam logic [CC_W-1:0] CC_ONE = 1;
  localparam logic [K-1:0]    K_ONE  = 1;

  step_e              st;
  op_e                op_q;
  logic [SEG_W-1:0]   seg_q;
  logic [LW-1:0]      len_q, rlen_q;
  logic [K-2:0]       val_q;
  logic [R_W-1:0]     route_q;
  logic [K-1:0]       cnt_q;
  logic [CC_W-1:0]    delta_q;
  logic [WORD_W-1:0]  hold_q;

  logic [K-1:0]  rs_off, exp_off, rst_off;
  logic          last;
  logic          nxt_v, take_route, need_rst, cc_up, cc_dn;
  logic [K-2:0]  nxt_vsp;
  logic [LW-1:0] rst_len;
  logic [WORD_W-1:0] ex_word, rs_word, rt_word, cc_word;

  // named events for the checks
  logic ex_wr_ev, rt_wr_ev, cc_wr_ev;
  assign ex_wr_ev = (st == ST_EX_WR) && !need_rst;
  assign rt_wr_ev = (st == ST_RT_WR);
  assign cc_wr_ev = (st == ST_CC_WR);

  subpfx_addr_gen #(.K(K), .LW(LW)) u_addr (
    .len(len_q), .val(val_q), .cnt(cnt_q), .rlen(rlen_q),
    .rs_off(rs_off), .exp_off(exp_off), .rst_off(rst_off), .last(last)
  );

  subpfx_word_rule #(.K(K), .LW(LW)) u_rule (
    .del(op_q == OP_DEL), .len(len_q),
    .cur_v(mem_rdata[P_V]), .cur_s(mem_rdata[P_S]), .cur_f(mem_rdata[P_F]),
    .cur_vsp(mem_rdata[P_VSP +: K-1]),
    .nxt_v(nxt_v), .nxt_vsp(nxt_vsp), .take_route(take_route),
    .need_rst(need_rst), .rst_len(rst_len), .cc_up(cc_up), .cc_dn(cc_dn)
  );

  always_comb begin
    ex_word = mem_rdata;
    ex_word[P_V] = nxt_v;
    ex_word[P_VSP +: K-1] = nxt_vsp;
    if (take_route) ex_word[P_R +: R_W] = route_q;
    rs_word = mem_rdata;
    rs_word[P_RS +: R_W] = (op_q == OP_DEL) ? '0 : route_q;
    rt_word = hold_q;
    rt_word[P_R +: R_W] = mem_rdata[P_RS +: R_W];
    cc_word = mem_rdata;
    cc_word[P_CC +: CC_W] = mem_rdata[P_CC +: CC_W] + delta_q;
  end

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_RS_RD: begin mem_re = 1'b1; mem_addr = {seg_q, rs_off}; end
      ST_RS_WR: begin mem_we = 1'b1; mem_addr = {seg_q, rs_off}; mem_wdata = rs_word; end
      ST_EX_RD: begin mem_re = 1'b1; mem_addr = {seg_q, exp_off}; end
      ST_EX_WR: begin mem_we = !need_rst; mem_addr = {seg_q, exp_off}; mem_wdata = ex_word; end
      ST_RT_RD: begin mem_re = 1'b1; mem_addr = {seg_q, rst_off}; end
      ST_RT_WR: begin mem_we = 1'b1; mem_addr = {seg_q, exp_off}; mem_wdata = rt_word; end
      ST_CC_RD: begin mem_re = 1'b1; mem_addr = {seg_q, {K{1'b0}}}; end
      ST_CC_WR: begin mem_we = 1'b1; mem_addr = {seg_q, {K{1'b0}}}; mem_wdata = cc_word; end
      default: ;
    endcase
  end

  assign done = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= OP_INS;
      seg_q   <= '0;
      len_q   <= '0;
      rlen_q  <= '0;
      val_q   <= '0;
      route_q <= '0;
      cnt_q   <= '0;
      delta_q <= '0;
      hold_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          op_q    <= op_e'(op);
          seg_q   <= seg;
          len_q   <= sp_len;
          val_q   <= sp_val;
          route_q <= route;
          cnt_q   <= '0;
          delta_q <= '0;
          st      <= ST_RS_RD;
        end
        ST_RS_RD: st <= ST_RS_WR;
        ST_RS_WR: st <= ST_EX_RD;
        ST_EX_RD: st <= ST_EX_WR;
        ST_EX_WR: begin
          if (need_rst) begin
            hold_q <= ex_word;
            rlen_q <= rst_len;
            st     <= ST_RT_RD;
          end else begin
            if (cc_up) delta_q <= delta_q + CC_ONE;
            else if (cc_dn) delta_q <= delta_q - CC_ONE;
            if (last) st <= ST_CC_RD;
            else begin
              cnt_q <= cnt_q + K_ONE;
              st    <= ST_EX_RD;
            end
          end
        end
        ST_RT_RD: st <= ST_RT_WR;
        ST_RT_WR: begin
          if (last) st <= ST_CC_RD;
          else begin
            cnt_q <= cnt_q + K_ONE;
            st    <= ST_EX_RD;
          end
        end
        ST_CC_RD: st <= ST_CC_WR;
        ST_CC_WR: st <= ST_FIN;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R9
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R9
  ex_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_ev |-> mem_addr == $past(mem_addr));

  // R4
  f_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_ev |-> mem_wdata[P_F] == mem_rdata[P_F]);

  // R3
  ins_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wr_ev && op_q == OP_INS) |-> mem_wdata[P_V]);

  // R2
  vsp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_wr_ev |-> mem_wdata[P_VSP + int'(len_q) - 1] == (op_q == OP_INS));

  // R6
  rst_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_wr_ev |-> $past(mem_re) && mem_addr[K-1:0] == exp_off);

  // R8
  cc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_wr_ev |-> mem_addr[K-1:0] == '0);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cc_wr_ev));

endmodule

// File: tb/sim_subpfx_node_upd.sv
`timescale 1ns/1ps
module sim_subpfx_node_upd;
  localparam int K = 4, SEG_W = 3, R_W = 8, LW = 2;
  localparam int WW = 27;
  localparam int B_V = 0, B_S = 1, B_F = 2, B_VSP = 3, B_R = 6, B_RS = 14, B_CC = 22;
  localparam int SEG = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op = 1'b0;
  logic [SEG_W-1:0] seg = '0;
  logic [LW-1:0] sp_len = '0;
  logic [K-2:0] sp_val = '0;
  logic [R_W-1:0] route = '0;
  logic done, mem_re, mem_we;
  logic [SEG_W+K-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata;
  logic [WW-1:0] mem [128];
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  subpfx_node_upd #(.K(K), .SEG_W(SEG_W), .R_W(R_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .seg(seg),
    .sp_len(sp_len), .sp_val(sp_val), .route(route), .done(done),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  typedef struct packed {
    logic       op;
    logic [1:0] len;
    logic [2:0] val;
    logic [7:0] rt;
    logic [3:0] chk;
    logic [7:0] er;
    logic       ev;
    logic [2:0] evsp;
    logic [3:0] rso;
    logic [7:0] ers;
    logic [4:0] ecc;
  } vec_t;

  localparam int N = 12;
  localparam vec_t TBL [N] = '{
    '{1'b0, 2'd2, 3'b011, 8'hA1, 4'hC, 8'hA1, 1'b1, 3'b010, 4'hE, 8'hA1, 5'd5}, // R1 R3 R5(F word kept)
    '{1'b0, 2'd3, 3'b111, 8'hB2, 4'hF, 8'hB2, 1'b1, 3'b110, 4'hF, 8'hB2, 5'd5}, // R4 replace shorter
    '{1'b0, 2'd1, 3'b001, 8'hC3, 4'hC, 8'hA1, 1'b1, 3'b011, 4'hC, 8'hC3, 5'd9}, // R4 keep longer
    '{1'b1, 2'd3, 3'b111, 8'h00, 4'hF, 8'hA1, 1'b1, 3'b011, 4'hF, 8'h00, 5'd9}, // R6 restore len 2
    '{1'b1, 2'd2, 3'b011, 8'h00, 4'hD, 8'hC3, 1'b1, 3'b001, 4'hE, 8'h00, 5'd9}, // R6 restore len 1
    '{1'b1, 2'd1, 3'b001, 8'h00, 4'hA, 8'hC3, 1'b0, 3'b000, 4'hC, 8'h00, 5'd2}, // R7 invalidate
    '{1'b1, 2'd1, 3'b000, 8'h00, 4'h5, 8'h00, 1'b0, 3'b000, 4'h4, 8'h00, 5'd2}, // R5 V=0 untouched
    '{1'b0, 2'd1, 3'b110, 8'hD4, 4'h3, 8'hD4, 1'b1, 3'b001, 4'h4, 8'hD4, 5'd9}, // R2 high bits ignored, R3 S=0
    '{1'b1, 2'd1, 3'b000, 8'h00, 4'h3, 8'hD4, 1'b0, 3'b000, 4'h4, 8'h00, 5'd2}, // R7 S=0 no decrement
    '{1'b0, 2'd2, 3'b000, 8'hE5, 4'h1, 8'hE5, 1'b1, 3'b010, 4'h2, 8'hE5, 5'd5}, // R3 R1
    '{1'b0, 2'd1, 3'b000, 8'hF6, 4'h2, 8'hE5, 1'b1, 3'b011, 4'h4, 8'hF6, 5'd9}, // R4
    '{1'b1, 2'd1, 3'b000, 8'h00, 4'h0, 8'hE5, 1'b1, 3'b010, 4'h4, 8'h00, 5'd5}  // R5 longer kept, R8
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int addr(input int sg, input int off);
    return sg * 16 + off;
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R8 done seen", int'(done), 1);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
  endtask

  task automatic run_op(input logic o, input logic [1:0] l, input logic [2:0] v,
                        input logic [7:0] r, input int sg);
    @(negedge clk);
    op = o; sp_len = l; sp_val = v; route = r; seg = SEG_W'(sg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = WW'(1 << B_S);
    mem[addr(SEG, 4'hE)] = WW'((8'h55 << B_R) | (1 << B_F) | (1 << B_S) | (1 << B_V));
    mem[addr(SEG, 4'h3)] = '0;                       // has a child: S=0
    mem[addr(SEG, 0)]    = WW'((2 << B_CC) | (1 << B_S));
    repeat (3) @(negedge clk);
    // reset state (R8, R9)
    check("R8 reset done", int'(done), 0);
    check("R9 reset re", int'(mem_re), 0);
    check("R9 reset we", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      run_op(TBL[i].op, TBL[i].len, TBL[i].val, TBL[i].rt, SEG);
      check($sformatf("R2/R3..R7 step%0d word R", i), int'(mem[addr(SEG, TBL[i].chk)][B_R +: 8]), int'(TBL[i].er));
      check($sformatf("R3/R7 step%0d word V", i), int'(mem[addr(SEG, TBL[i].chk)][B_V]), int'(TBL[i].ev));
      check($sformatf("R2 step%0d word VSP", i), int'(mem[addr(SEG, TBL[i].chk)][B_VSP +: 3]), int'(TBL[i].evsp));
      check($sformatf("R1 step%0d RS", i), int'(mem[addr(SEG, TBL[i].rso)][B_RS +: 8]), int'(TBL[i].ers));
      check($sformatf("R8 step%0d count", i), int'(mem[addr(SEG, 0)][B_CC +: 5]), int'(TBL[i].ecc));
    end

    // R5: full-prefix word untouched through all operations
    check("R5 F word R", int'(mem[addr(SEG, 4'hE)][B_R +: 8]), 8'h55);
    check("R5 F word V", int'(mem[addr(SEG, 4'hE)][B_V]), 1);
    check("R4 F flag kept", int'(mem[addr(SEG, 4'hE)][B_F]), 1);

    // R8: start while busy is ignored
    @(negedge clk);
    op = 1'b0; sp_len = 2'd2; sp_val = 3'b010; route = 8'h9A; seg = SEG_W'(SEG); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 1'b0; sp_len = 2'd3; sp_val = 3'b001; route = 8'h77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    check("R8 busy start no RS", int'(mem[addr(SEG, 4'h3)][B_RS +: 8]), 0);
    check("R8 busy start no VSP", int'(mem[addr(SEG, 4'h2)][B_VSP +: 3]), 3'b010);
    check("R3 busy op word", int'(mem[addr(SEG, 4'h9)][B_R +: 8]), 8'h9A);
    check("R1 busy op RS", int'(mem[addr(SEG, 4'hA)][B_RS +: 8]), 8'h9A);
    check("R8 busy op count", int'(mem[addr(SEG, 0)][B_CC +: 5]), 9);

    // R9: address is {segment, offset}
    run_op(1'b0, 2'd3, 3'b101, 8'h3C, 1);
    check("R9 other segment RS", int'(mem[addr(1, 4'hB)][B_RS +: 8]), 8'h3C);
    check("R9 other segment count", int'(mem[addr(1, 0)][B_CC +: 5]), 2);
    check("R9 node untouched", int'(mem[addr(SEG, 0)][B_CC +: 5]), 9);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule